// File: doc/BRIEF.md
# Serial Three-Wire Bus Byte Monitor

This block listens, without ever driving anything, to the three open-collector lines of a three-wire serial peripheral bus: a data line, a clock line and an attention line. It follows the talker/listener handshake on those lines and rebuilds every byte that crosses the bus. For each byte it gives the value, a command flag (the byte was sent while attention was asserted, i.e. the attention line was low) and an end-of-information flag (the talker signalled that this is the last byte). A one-cycle valid strobe marks each new result.

The bus lines are asynchronous to the system clock. Each one passes through a synchronizer chain. The monitor then detects edges by comparing each synchronized sample with the one taken a cycle earlier. The receiver is a four-state machine:
- `ST_IDLE`: waiting for a talker.
- `ST_READY`: the talker has announced it is ready to send.
- `ST_EOIWAIT`: the listener has released data, and the machine watches for the end-of-information pulse.
- `ST_BITS`: bit reception.

Its transitions are:
- `T_ANNOUNCE`: `ST_IDLE` to `ST_READY`.
- `T_START`: `ST_READY` to `ST_EOIWAIT`.
- `T_ABORT`: `ST_READY` to `ST_IDLE`.
- `T_CLKLOW`: `ST_EOIWAIT` to `ST_BITS`.
- `T_DONE`: `ST_BITS` to `ST_IDLE`.
- `T_ATTN`: any state to `ST_IDLE`.

Top module: `serbus_byte_monitor`

## Requirements
- R1: After reset the machine is in `ST_IDLE`, `valid_o` is 0, and `byte_o`, `cmd_o` and `eoi_o` are 0. The previous-sample registers and synchronizers reset to 1 (the released bus), so no edge is seen when reset is released.
- R2: `T_ANNOUNCE`: in `ST_IDLE`, a sampled clock line at 1 together with a data line at 0 moves the machine to `ST_READY`.
- R3: `T_START`: in `ST_READY`, data at 1 while clock is at 1 moves the machine to `ST_EOIWAIT`. At that moment the byte register and bit count are cleared, the end flag is cleared, and the command flag is set to the inverse of the attention level: attention low gives `cmd_o` = 1 for that byte.
- R4: `T_ABORT`: in `ST_READY`, clock at 0 before data has risen returns the machine to `ST_IDLE`, and no byte is reported.
- R5: In `ST_EOIWAIT`, data at 0 while clock is at 1 sets the end flag, so that byte is reported with `eoi_o` = 1.
- R6: `T_CLKLOW`: in `ST_EOIWAIT`, the first 0 on the clock line moves the machine to `ST_BITS`.
- R7: In `ST_BITS`, the data line is captured on each rising clock-line edge. The first captured bit becomes bit 0 of `byte_o` (least significant first).
- R8: `T_DONE`: each falling clock-line edge in `ST_BITS` completes a bit. On the eighth one, `byte_o`, `cmd_o` and `eoi_o` are loaded, `valid_o` is 1 for exactly one system cycle, and the machine returns to `ST_IDLE`.
- R9: `byte_o`, `cmd_o` and `eoi_o` stay unchanged from one report until the next.
- R10: `T_ATTN`: a falling edge on the attention line, in any state, forces `ST_IDLE`. A partly received byte is dropped and never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data_i | input | 1 | Data line level (asynchronous) |
| bus_clk_i | input | 1 | Bus clock line level (asynchronous) |
| bus_atn_i | input | 1 | Attention line level, low = asserted (asynchronous) |
| byte_o | output | 8 | Last received byte |
| cmd_o | output | 1 | Last byte was sent under attention |
| eoi_o | output | 1 | Last byte carried end-of-information |
| valid_o | output | 1 | One-cycle strobe when a new byte is reported |

## Verification
A change on a bus pin reaches the state machine after the two synchronizer flops. The machine acts on it at the third rising edge, so `valid_o` rises three system cycles after the eighth falling edge on the clock pin.

The driver therefore holds every bus level for four cycles, longer than this latency. It queues the expected byte before the final clock fall. The monitor compares at each falling system-clock edge while `valid_o` is high, and also checks that the strobe has dropped one cycle later. Hold and no-report checks are made only after several quiet cycles, by which time any report would already have appeared.

// File: rtl/serbus_mon_pkg.sv
package serbus_mon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READY   = 2'd1,
        ST_EOIWAIT = 2'd2,
        ST_BITS    = 2'd3
    } rx_state_t;

    localparam int LINES = 3;
    localparam int IDX_DATA = 0;
    localparam int IDX_CLK  = 1;
    localparam int IDX_ATN  = 2;
endpackage

// File: rtl/serbus_line_sync.sv
module serbus_line_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= '1;
            end else if (s == 0) begin
                chain[s] <= async_i;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/serbus_rx_fsm.sv
module serbus_rx_fsm
    import serbus_mon_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 data_s,
    input  logic                 clk_s,
    input  logic                 atn_s,
    output logic [BYTE_BITS-1:0] byte_o,
    output logic                 cmd_o,
    output logic                 eoi_o,
    output logic                 valid_o
);
    localparam int CNT_W = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

    rx_state_t            st_q, st_d;
    logic                 clk_prev, atn_prev;
    logic [BYTE_BITS-1:0] shift_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 cmd_w, eoi_w;

    logic clk_rise, clk_fall, atn_fall;
    assign clk_rise = clk_s & ~clk_prev;
    assign clk_fall = ~clk_s & clk_prev;
    assign atn_fall = ~atn_s & atn_prev;

    // previous-sample registers, reset to released bus level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev <= 1'b1;
            atn_prev <= 1'b1;
        end else begin
            clk_prev <= clk_s;
            atn_prev <= atn_s;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (atn_fall) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:    if (!data_s && clk_s) st_d = ST_READY;
                ST_READY: begin
                    if (data_s && clk_s)  st_d = ST_EOIWAIT;
                    else if (!clk_s)      st_d = ST_IDLE;
                end
                ST_EOIWAIT: if (!clk_s) st_d = ST_BITS;
                ST_BITS:    if (clk_fall && cnt_q == LAST_BIT) st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
            cmd_w   <= 1'b0;
            eoi_w   <= 1'b0;
            byte_o  <= '0;
            cmd_o   <= 1'b0;
            eoi_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (!atn_fall) begin
                unique case (st_q)
                    ST_IDLE: ;
                    ST_READY: begin
                        if (data_s && clk_s) begin
                            shift_q <= '0;
                            cnt_q   <= '0;
                            eoi_w   <= 1'b0;
                            cmd_w   <= ~atn_s;
                        end
                    end
                    ST_EOIWAIT: begin
                        if (!data_s && clk_s) eoi_w <= 1'b1;
                    end
                    ST_BITS: begin
                        if (clk_rise) shift_q[cnt_q] <= data_s;
                        if (clk_fall) begin
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == LAST_BIT) begin
                                byte_o  <= shift_q;
                                cmd_o   <= cmd_w;
                                eoi_o   <= eoi_w;
                                valid_o <= 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    a_r10_atn_abort: assert property (@(posedge clk) disable iff (!rst_n)
        atn_fall |=> (st_q == ST_IDLE && !valid_o));
    a_r2_announce: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !atn_fall && !data_s && clk_s) |=> st_q == ST_READY);
    a_r4_ready_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY && !atn_fall && !clk_s) |=> (st_q == ST_IDLE && !valid_o));
    a_r6_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EOIWAIT && !atn_fall && !clk_s) |=> st_q == ST_BITS);
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    a_r8_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> st_q == ST_IDLE);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (valid_o || ($stable(byte_o) && $stable(cmd_o) && $stable(eoi_o))));
endmodule

// File: rtl/serbus_byte_monitor.sv
module serbus_byte_monitor
    import serbus_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_data_i,
    input  logic                 bus_clk_i,
    input  logic                 bus_atn_i,
    output logic [BYTE_BITS-1:0] byte_o,
    output logic                 cmd_o,
    output logic                 eoi_o,
    output logic                 valid_o
);
    logic [LINES-1:0] raw, synced;

    always_comb begin
        raw = '1;
        raw[IDX_DATA] = bus_data_i;
        raw[IDX_CLK]  = bus_clk_i;
        raw[IDX_ATN]  = bus_atn_i;
    end

    serbus_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    serbus_rx_fsm #(.BYTE_BITS(BYTE_BITS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_s  (synced[IDX_DATA]),
        .clk_s   (synced[IDX_CLK]),
        .atn_s   (synced[IDX_ATN]),
        .byte_o  (byte_o),
        .cmd_o   (cmd_o),
        .eoi_o   (eoi_o),
        .valid_o (valid_o)
    );
endmodule

// File: tb/tb_serbus_byte_monitor.sv
`timescale 1ns/1ps
module tb_serbus_byte_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_data = 1'b1, bus_clk = 1'b1, bus_atn = 1'b1;
    logic [7:0] byte_o;
    logic cmd_o, eoi_o, valid_o;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int popped = 0;
    logic [9:0] exp_q [$];
    logic [9:0] last_exp = '0;
    logic prev_valid = 1'b0;

    always #5 clk = ~clk;

    serbus_byte_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .bus_data_i(bus_data), .bus_clk_i(bus_clk), .bus_atn_i(bus_atn),
        .byte_o(byte_o), .cmd_o(cmd_o), .eoi_o(eoi_o), .valid_o(valid_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic step();
        repeat (4) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid) check(!valid_o, "R8 strobe longer than one cycle", {31'd0, valid_o}, 0);
            if (valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4/R10 unexpected byte reported", {22'd0, cmd_o, eoi_o, byte_o}, 0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    popped++;
                    check(byte_o == e[7:0], "R7 byte value LSB first", {24'd0, byte_o}, {24'd0, e[7:0]});
                    check(cmd_o == e[9], "R3 command flag", {31'd0, cmd_o}, {31'd0, e[9]});
                    check(eoi_o == e[8], "R5 end flag", {31'd0, eoi_o}, {31'd0, e[8]});
                end
            end
            prev_valid <= valid_o;
        end
    end

    task automatic hold_check(input string req);
        check({cmd_o, eoi_o, byte_o} == last_exp && !valid_o, req,
              {21'd0, valid_o, cmd_o, eoi_o, byte_o}, {22'd0, last_exp});
    endtask

    // talker + listener handshake; nbits < 8 ends with an attention drop
    task automatic send_byte(input logic [7:0] b, input bit atn_low, input bit eoi, input int nbits);
        if (atn_low) bus_atn = 1'b0;
        step();
        bus_clk = 1'b0; step();
        bus_data = 1'b0; step();
        bus_clk = 1'b1; step();           // R2 announce
        bus_data = 1'b1; step();          // R3 start
        if (eoi) begin
            bus_data = 1'b0; step();      // R5 end pulse
            bus_data = 1'b1; step();
        end
        bus_clk = 1'b0; step();           // R6 into bits
        for (int i = 0; i < nbits; i++) begin
            bus_data = b[i]; step();
            bus_clk = 1'b1; step();
            if (i == 7) begin
                exp_q.push_back({atn_low, eoi, b});
                pushed++;
                last_exp = {atn_low, eoi, b};
            end
            bus_clk = 1'b0; step();
        end
        if (nbits < 8) begin
            bus_atn = 1'b0; step();       // R10 abort mid byte
            bus_data = 1'b0; step();
        end else begin
            bus_data = 1'b0; step();
            if (atn_low) bus_atn = 1'b1;
            step();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R1 valid in reset", {31'd0, valid_o}, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(valid_o == 1'b0, "R1 valid after reset", {31'd0, valid_o}, 0);
        check(byte_o == 8'h00, "R1 byte after reset", {24'd0, byte_o}, 0);
        check({cmd_o, eoi_o} == 2'b00, "R1 flags after reset", {30'd0, cmd_o, eoi_o}, 0);

        send_byte(8'hA5, 1'b0, 1'b0, 8);
        send_byte(8'h28, 1'b1, 1'b0, 8);
        hold_check("R9 outputs held after command byte");
        send_byte(8'h3C, 1'b0, 1'b1, 8);

        // R4: clock drops while ready, no byte
        bus_clk = 1'b0; step();
        bus_data = 1'b0; step();
        bus_clk = 1'b1; step();
        bus_clk = 1'b0; step();
        bus_data = 1'b1; step();
        step();
        hold_check("R4 abort in ready reports nothing");

        send_byte(8'h00, 1'b0, 1'b0, 8);
        send_byte(8'hFF, 1'b0, 1'b1, 8);
        send_byte(8'h5A, 1'b0, 1'b0, 4);
        step(); step();
        hold_check("R10 partial byte dropped");
        send_byte(8'h61, 1'b1, 1'b0, 8);
        step();
        hold_check("R9 outputs held after last byte");

        check(exp_q.size() == 0, "R8 all expected bytes reported", exp_q.size(), 0);
        check(popped == pushed, "R8 report count", popped, pushed);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule